// File: doc/BRIEF.md
# Embedded-Clock Serializer Link Controller

This block is the transmit-side controller of a 10-bit serial link whose receiver recovers timing from the data stream itself. It runs on a bit-rate clock. A slot counter splits that clock into 12-bit word periods and produces a word clock. Each parallel word is captured on the rising or the falling edge of that word clock, as chosen by a select input. It is then wrapped in a 12-bit frame: a 1 start bit, data bits 0 to 9 sent least significant first, and a 0 stop bit. Every frame boundary therefore carries a guaranteed 0-to-1 transition.

A mode controller chooses, at each frame boundary, between data frames and sync frames. A sync frame is six 1s followed by six 0s. Sync frames are sent for a fixed number of frames after leaving sleep or reset, and for as long as either of two sync request inputs is held. An active-low power-down input puts the block to sleep: the slot counter freezes, the word clock stops and the serial output floats. An output-enable input floats the serial output without disturbing the sequencing. The serial side is modelled as a data bit plus a drive-enable flag.

Top module: `ecs_serializer`

## Requirements
- R1: In data mode each frame lasts 12 bit-clock cycles. Slot 0 carries 1, slots 1 to 10 carry din[0] to din[9], and slot 11 carries 0. The word clock wclk_o is high in slots 0 to 5 and low in slots 6 to 11.
- R2: While sync_a or sync_b is 1, either one alone being enough, every frame is the sync frame: 1 in slots 0 to 5 and 0 in slots 6 to 11.
- R3: The sync requests are sampled only at the frame boundary, the clock edge that ends slot 11. A frame already in progress completes unchanged, and the next frame follows the new request.
- R4: After reset, or after wake from sleep, the block sends exactly INIT_FRAMES sync frames (default 510) regardless of the sync requests. After that it sends data frames, or sync frames while a request is held.
- R5: With edge_sel = 0, din is captured at the edge where wclk_o rises (end of slot 11). With edge_sel = 1, din is captured at the edge where wclk_o falls (end of slot 5). The captured word is sent in the frame loaded at the next frame boundary.
- R6: With pwrdn_n low at a clock edge, from the next cycle ser_oe, ser_o and wclk_o are 0 and stay 0 until pwrdn_n is high again. Raising pwrdn_n restarts at slot 0 with the initialization of R4.
- R7: While den is 0, ser_oe and ser_o are 0 in the same cycle. Slot timing and mode continue, so raising den resumes the data stream in frame alignment.
- R8: While rst_n is low, ser_oe, ser_o and wclk_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low sleep request |
| den | input | 1 | Serial output enable |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| edge_sel | input | 1 | Capture edge: 0 rising, 1 falling word clock |
| din | input | 10 | Parallel data word |
| wclk_o | output | 1 | Word clock, high for the first half of each frame |
| ser_o | output | 1 | Serial bit |
| ser_oe | output | 1 | Serial drive enable; 0 means floating |

## Verification
Data frames are checked with all-ones, all-zeros and both alternating patterns, and with irregular words. These tell a correct bit order and start/stop framing apart from reversed or shifted framing. Sync requests are raised on each input alone and on both together. One is also raised in the middle of a frame, which separates boundary sampling from immediate switching. For the capture edge, a word is changed part way through a frame so that the falling and rising selections must send different words. Sync frames after reset and after wake are counted, which catches an initialization one frame too short or too long.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  localparam int DATA_W  = 10;
  localparam int FRAME_W = DATA_W + 2;
  localparam int HALF_W  = FRAME_W / 2;

  typedef enum logic [1:0] {
    M_SLEEP = 2'd0,
    M_INIT  = 2'd1,
    M_SYNC  = 2'd2,
    M_DATA  = 2'd3
  } mode_e;

  // start bit at position 0 (sent first), stop bit at the top
  function automatic logic [FRAME_W-1:0] data_frame(input logic [DATA_W-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  function automatic logic [FRAME_W-1:0] sync_frame();
    return {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  endfunction
endpackage

// File: rtl/ecs_slot_timer.sv
module ecs_slot_timer #(
  parameter int FRAME_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake,
  input  logic run,
  output logic slot_last,
  output logic slot_mid,
  output logic wclk
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int HALF  = FRAME_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en    = 1'b1;
  assign slot_last = run && (cnt_q == CNT_W'(FRAME_W - 1));
  assign slot_mid  = run && (cnt_q == CNT_W'(HALF - 1));
  assign wclk      = awake && (cnt_q < CNT_W'(HALF));

  always_comb begin
    if (!run)           cnt_d = '0;
    else if (slot_last) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ecs_mode_ctl.sv
module ecs_mode_ctl #(
  parameter int INIT_FRAMES = 510
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrdn_n,
  input  logic          sync_req,
  input  logic          slot_last,
  output ecs_pkg::mode_e mode_q,
  output logic          load,
  output logic          load_sync
);
  import ecs_pkg::*;
  localparam int ICNT_W = (INIT_FRAMES > 1) ? $clog2(INIT_FRAMES) : 1;

  mode_e             mode_d;
  logic [ICNT_W-1:0] icnt_q, icnt_d;
  logic              init_done;

  assign init_done = (icnt_q == ICNT_W'(INIT_FRAMES - 1));

  always_comb begin
    mode_d = mode_q;
    icnt_d = icnt_q;
    load   = 1'b0;
    if (mode_q == M_SLEEP) begin
      if (pwrdn_n) begin
        mode_d = M_INIT;
        icnt_d = '0;
        load   = 1'b1;
      end
    end else if (!pwrdn_n) begin
      mode_d = M_SLEEP;
    end else if (slot_last) begin
      load = 1'b1;
      if (mode_q == M_INIT && !init_done) begin
        icnt_d = icnt_q + 1'b1;
      end else begin
        mode_d = sync_req ? M_SYNC : M_DATA;
      end
    end
  end

  assign load_sync = (mode_d != M_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_SLEEP;
      icnt_q <= '0;
    end else begin
      mode_q <= mode_d;
      icnt_q <= icnt_d;
    end
  end
endmodule

// File: rtl/ecs_word_latch.sv
module ecs_word_latch #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_sel,
  input  logic              slot_last,
  input  logic              slot_mid,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] word_q
);
  logic cap_en;

  assign cap_en = edge_sel ? slot_mid : slot_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (cap_en) word_q <= din;
  end
endmodule

// File: rtl/ecs_frame_shifter.sv
module ecs_frame_shifter #(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              load,
  input  logic              load_sync,
  input  logic [DATA_W-1:0] word,
  output logic              bit_o
);
  import ecs_pkg::*;

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sh_en;

  assign sh_en = load || awake;

  always_comb begin
    if (load)
      sh_d = load_sync ? sync_frame() : data_frame(word);
    else
      sh_d = {1'b0, sh_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/ecs_serializer.sv
module ecs_serializer #(
  parameter int INIT_FRAMES = 510
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn_n,
  input  logic       den,
  input  logic       sync_a,
  input  logic       sync_b,
  input  logic       edge_sel,
  input  logic [9:0] din,
  output logic       wclk_o,
  output logic       ser_o,
  output logic       ser_oe
);
  import ecs_pkg::*;

  mode_e             mode_q;
  logic              awake, run;
  logic              slot_last, slot_mid;
  logic              load, load_sync;
  logic [DATA_W-1:0] word_q;
  logic              sh_bit;

  assign awake = (mode_q != M_SLEEP);
  assign run   = awake && pwrdn_n;

  ecs_slot_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .awake(awake), .run(run),
    .slot_last(slot_last), .slot_mid(slot_mid), .wclk(wclk_o)
  );

  ecs_mode_ctl #(.INIT_FRAMES(INIT_FRAMES)) u_mode (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .sync_req(sync_a | sync_b),
    .slot_last(slot_last), .mode_q(mode_q), .load(load), .load_sync(load_sync)
  );

  ecs_word_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .slot_last(slot_last),
    .slot_mid(slot_mid), .din(din), .word_q(word_q)
  );

  ecs_frame_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .awake(awake), .load(load),
    .load_sync(load_sync), .word(word_q), .bit_o(sh_bit)
  );

  assign ser_oe = den && awake;
  assign ser_o  = ser_oe && sh_bit;
endmodule

// File: rtl/ecs_serializer_chk.sv
module ecs_serializer_chk #(
  parameter int INIT_FRAMES = 510
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwrdn_n,
  input logic           den,
  input logic           wclk_o,
  input logic           ser_o,
  input logic           ser_oe,
  input ecs_pkg::mode_e mode_q
);
  import ecs_pkg::*;

  int unsigned init_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                init_cyc <= 0;
    else if (mode_q == M_INIT) init_cyc <= init_cyc + 1;
    else                       init_cyc <= 0;
  end

  // R6
  sleep_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> (!ser_oe && !ser_o && !wclk_o));

  // R1
  data_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wclk_o) && mode_q == M_DATA && den) |-> ser_o);

  // R2
  sync_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wclk_o) && mode_q == M_SYNC && den) |-> ser_o);

  // R4
  init_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_INIT && (mode_q == M_SYNC || mode_q == M_DATA))
      |-> (init_cyc == INIT_FRAMES * FRAME_W));

  // R7
  den_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(den) && pwrdn_n && mode_q != M_SLEEP) |-> ser_oe);
endmodule

bind ecs_serializer ecs_serializer_chk #(.INIT_FRAMES(INIT_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .den(den), .wclk_o(wclk_o),
  .ser_o(ser_o), .ser_oe(ser_oe), .mode_q(mode_q)
);

// File: tb/ecs_serializer_bench.sv
module ecs_serializer_bench;
  localparam int          NINIT = 510;
  localparam logic [11:0] SYNC  = 12'h03F;

  logic       clk = 1'b0;
  logic       rst_n, pwrdn_n, den, sync_a, sync_b, edge_sel;
  logic [9:0] din;
  logic       wclk_o, ser_o, ser_oe;
  int         tests = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  ecs_serializer #(.INIT_FRAMES(NINIT)) u_ecs_serializer (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .den(den), .sync_a(sync_a),
    .sync_b(sync_b), .edge_sel(edge_sel), .din(din), .wclk_o(wclk_o),
    .ser_o(ser_o), .ser_oe(ser_oe)
  );

  // {sync_a, sync_b, din}
  localparam logic [11:0] VEC [8] = '{
    {2'b00, 10'h3FF}, {2'b00, 10'h000}, {2'b00, 10'h2AA}, {2'b00, 10'h155},
    {2'b10, 10'h123}, {2'b01, 10'h0F0}, {2'b11, 10'h201}, {2'b00, 10'h3C1}
  };

  function automatic logic [11:0] dframe(input logic [9:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // waits for the next word-clock rise, then reads slots 0..11
  task automatic grab(output logic [11:0] f);
    logic prv;
    do begin
      prv = wclk_o;
      @(negedge clk);
    end while (!(wclk_o && !prv));
    f[0] = ser_o;
    for (int i = 1; i < 12; i++) begin
      @(negedge clk);
      f[i] = ser_o;
    end
  endtask

  task automatic count_init(input string tag);
    logic [11:0] f;
    int          n = 0;
    grab(f);
    while (f == SYNC && n < 600) begin
      n++;
      grab(f);
    end
    check(n == NINIT, {tag, " sync frame count"}, n, NINIT);
    check(f == dframe(din), {tag, " first data frame"}, f, dframe(din));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [11:0] f;
    logic [11:0] e;
    rst_n = 1'b0; pwrdn_n = 1'b1; den = 1'b1; sync_a = 1'b0; sync_b = 1'b0;
    edge_sel = 1'b0; din = 10'h2C5;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!ser_oe && !ser_o && !wclk_o, "R8 outputs in reset",
          {ser_oe, ser_o, wclk_o}, 3'b000);
    rst_n = 1'b1;

    // R4 initialization after reset
    count_init("R4 reset");

    // R1 R2 vector table
    for (int v = 0; v < 8; v++) begin
      {sync_a, sync_b, din} = VEC[v];
      repeat (3) grab(f);
      e = (VEC[v][11] || VEC[v][10]) ? SYNC : dframe(VEC[v][9:0]);
      check(f == e, (e == SYNC) ? "R2 sync frame" : "R1 data frame", f, e);
    end
    sync_a = 1'b0; sync_b = 1'b0;

    // R5 capture edge selection
    for (int es = 0; es < 2; es++) begin
      edge_sel = es[0];
      din = 10'h111;
      repeat (3) grab(f);
      @(negedge clk);            // slot 0
      din = 10'h222;
      repeat (9) @(negedge clk); // slot 9
      din = 10'h333;
      grab(f);
      e = es ? dframe(10'h222) : dframe(10'h111);
      check(f == e, es ? "R5 falling capture" : "R5 rising capture", f, e);
      grab(f);
      check(f == dframe(10'h333), "R5 later word", f, dframe(10'h333));
    end
    edge_sel = 1'b0;

    // R3 sync raised mid-frame
    din = 10'h26B;
    repeat (3) grab(f);
    @(negedge clk);
    repeat (4) @(negedge clk);   // slot 4
    sync_b = 1'b1;
    e = dframe(10'h26B);
    f = '0;
    for (int s = 5; s < 12; s++) begin
      @(negedge clk);
      f[s] = ser_o;
    end
    check(f[11:5] == e[11:5], "R3 frame in progress completes", f[11:5], e[11:5]);
    grab(f);
    check(f == SYNC, "R3 next frame is sync", f, SYNC);
    sync_b = 1'b0;
    repeat (2) grab(f);
    check(f == dframe(10'h26B), "R3 data after release", f, dframe(10'h26B));

    // R7 output enable
    @(negedge clk);
    den = 1'b0;
    @(negedge clk);
    check(!ser_oe && !ser_o, "R7 floated while den low", {ser_oe, ser_o}, 2'b00);
    repeat (25) @(negedge clk);
    check(!ser_oe && !ser_o, "R7 still floated", {ser_oe, ser_o}, 2'b00);
    den = 1'b1;
    grab(f);
    check(f == dframe(10'h26B) && ser_oe, "R7 resume aligned", f, dframe(10'h26B));

    // R6 sleep
    @(negedge clk);
    pwrdn_n = 1'b0;
    @(negedge clk);
    check(!ser_oe && !ser_o && !wclk_o, "R6 sleep outputs",
          {ser_oe, ser_o, wclk_o}, 3'b000);
    begin
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (ser_oe || ser_o || wclk_o) bad++;
      end
      check(bad == 0, "R6 word clock stopped", bad, 0);
    end
    din = 10'h0D7;
    pwrdn_n = 1'b1;
    count_init("R6 R4 wake");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule